// File: doc/BRIEF.md
# SCSI Bus Arbitration Controller

This block carries out the arbitration phase for a parallel SCSI initiator. Once software sets the start bit in its control register, the block watches the shared busy and select lines until the bus has been idle for a set number of cycles. It then claims the bus. It asserts busy and pulls its own ID line on the 8-bit data bus. Bus lines are active-low and open-collector, so the block drives output enables and reads back the wired bus levels.

The block can lose in two ways. If another device asserts select while the block is arbitrating, it loses on the next clock edge. If no foreign select appears, it samples the data lines when the arbitration delay ends, and it loses if any ID bit above its own is present. A larger ID number has higher priority, so ID 7 is highest. A loss releases the bus, sets a sticky status flag and gives a one-cycle loss pulse. A win gives a one-cycle win pulse.

The mode field decides what happens after a win. In full mode the block asserts select for a bus clear plus settle interval and then raises a ready signal. In simple mode it raises ready at once and leaves select to software. Every bus interval is a clock-cycle parameter.

Top module: `scsi_arbiter`

## Requirements
- R1: After reset the control register reads 0xC0 (full mode, start clear), no bus line is driven, and the win pulse, loss pulse, lost flag and ready signal are all low.
- R2: After a start, no bus line is driven until busy and select have both been deasserted for FREE_CYCLES consecutive cycles. Any busy or select activity restarts the count.
- R3: While arbitrating, the block drives busy and exactly one data line, bit `my_id`, and does not drive select.
- R4: A foreign select seen during arbitration releases busy and the ID line on the next cycle. It also gives a one-cycle loss pulse, sets the lost flag and clears the start bit.
- R5: With no foreign select, the decision is due ARB_DELAY cycles after the bus is claimed. The block loses if any data bit above `my_id` is low on the bus, and wins otherwise (including when no other ID is present or all other IDs are lower). A win gives a one-cycle win pulse.
- R6: In full mode (mode bits [7:6] = 11), after a win the block drives select together with busy and its ID. Ready rises SETTLE_CYCLES cycles after the win.
- R7: In simple mode (mode bits = 00), after a win select stays undriven and ready rises in the same cycle as the win pulse.
- R8: A start with a reserved mode code (01 or 10) stores the fields but leaves the start bit clear. No bus line is driven and no pulse is given.
- R9: Register writes made while waiting, arbitrating or settling are ignored. Register contents and timing stay unchanged.
- R10: Register layout: [7:6] mode, [5] start (reads 1 while a run is active), [4] attention-on-selection, [3] parity enable, [2] reserved (reads 0), [1:0] two stored flags. A write in idle with start clear updates only the fields.
- R11: Once ready is high, a register write with bit 5 clear releases every bus line and clears ready on the next cycle. A new start clears the lost flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| my_id | input | 3 | Own SCSI ID |
| bsy_n_in | input | 1 | Busy line level on the bus (low = asserted) |
| sel_n_in | input | 1 | Select line level on the bus (low = asserted) |
| data_n_in | input | 8 | Data line levels on the bus (low = asserted) |
| bsy_oe | output | 1 | Pull busy low |
| sel_oe | output | 1 | Pull select low |
| data_oe | output | 8 | Pull the matching data lines low |
| won_pulse | output | 1 | One-cycle arbitration win |
| lost_pulse | output | 1 | One-cycle arbitration loss |
| lost_flag | output | 1 | Sticky lost-arbitration status |
| go_sel | output | 1 | Selection may proceed |

## Verification
Take the clock edge that accepts a start write as edge 0. With a free bus, the block claims the bus at edge FREE_CYCLES. The win or loss pulse follows at edge FREE_CYCLES+ARB_DELAY. In full mode, ready follows at edge FREE_CYCLES+ARB_DELAY+SETTLE_CYCLES. A foreign select takes effect at the first edge that samples it, and a release write takes effect at the edge that accepts it. The bench counts falling edges from the start edge and compares each result at exactly the count the requirement predicts. It also checks the cycle just before each result, where one is due.

// File: rtl/scsi_arbiter.sv
module scsi_arbiter #(
  parameter int FREE_CYCLES   = 40,
  parameter int ARB_DELAY     = 120,
  parameter int SETTLE_CYCLES = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic [2:0] my_id,
  input  logic       bsy_n_in,
  input  logic       sel_n_in,
  input  logic [7:0] data_n_in,
  output logic       bsy_oe,
  output logic       sel_oe,
  output logic [7:0] data_oe,
  output logic       won_pulse,
  output logic       lost_pulse,
  output logic       lost_flag,
  output logic       go_sel
);

  localparam int MAXC = (FREE_CYCLES > ARB_DELAY) ?
                        ((FREE_CYCLES > SETTLE_CYCLES) ? FREE_CYCLES : SETTLE_CYCLES) :
                        ((ARB_DELAY > SETTLE_CYCLES) ? ARB_DELAY : SETTLE_CYCLES);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [1:0] M_SIMPLE = 2'b00;
  localparam logic [1:0] M_FULL   = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_FREE, S_ARB, S_SETTLE, S_DONE} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [1:0]  mode;
  logic        start, atn, par;
  logic [1:0]  flg;

  wire       bus_free = bsy_n_in & sel_n_in;
  wire [7:0] hi_mask  = 8'hFE << my_id;
  wire       higher   = |(~data_n_in & hi_mask);
  wire       mode_ok  = (ctl_wdata[7:6] == M_SIMPLE) || (ctl_wdata[7:6] == M_FULL);

  assign ctl_rdata = {mode, start, atn, par, 1'b0, flg};
  assign bsy_oe    = (st == S_ARB) || (st == S_SETTLE) || (st == S_DONE);
  assign data_oe   = bsy_oe ? (8'b1 << my_id) : 8'b0;
  assign sel_oe    = (st == S_SETTLE) || ((st == S_DONE) && (mode == M_FULL));
  assign go_sel    = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      mode       <= M_FULL;
      start      <= 1'b0;
      atn        <= 1'b0;
      par        <= 1'b0;
      flg        <= 2'b00;
      won_pulse  <= 1'b0;
      lost_pulse <= 1'b0;
      lost_flag  <= 1'b0;
    end else begin
      won_pulse  <= 1'b0;
      lost_pulse <= 1'b0;
      case (st)
        S_IDLE: if (ctl_we) begin
          mode <= ctl_wdata[7:6];
          atn  <= ctl_wdata[4];
          par  <= ctl_wdata[3];
          flg  <= ctl_wdata[1:0];
          if (ctl_wdata[5] && mode_ok) begin
            start     <= 1'b1;
            lost_flag <= 1'b0;
            cnt       <= '0;
            st        <= S_FREE;
          end else begin
            start <= 1'b0;
          end
        end
        S_FREE: begin
          if (!bus_free) cnt <= '0;
          else if (cnt == CW'(FREE_CYCLES - 1)) begin
            cnt <= '0;
            st  <= S_ARB;
          end else cnt <= cnt + 1'b1;
        end
        S_ARB: begin
          if (!sel_n_in || ((cnt == CW'(ARB_DELAY - 1)) && higher)) begin
            st         <= S_IDLE;
            start      <= 1'b0;
            lost_flag  <= 1'b1;
            lost_pulse <= 1'b1;
            cnt        <= '0;
          end else if (cnt == CW'(ARB_DELAY - 1)) begin
            won_pulse <= 1'b1;
            cnt       <= '0;
            st        <= (mode == M_FULL) ? S_SETTLE : S_DONE;
          end else cnt <= cnt + 1'b1;
        end
        S_SETTLE: begin
          if (cnt == CW'(SETTLE_CYCLES - 1)) begin
            cnt <= '0;
            st  <= S_DONE;
          end else cnt <= cnt + 1'b1;
        end
        S_DONE: if (ctl_we && !ctl_wdata[5]) begin
          start <= 1'b0;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4 R5
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(won_pulse && lost_pulse));

  // R4
  foreign_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARB && !sel_n_in) |=> (lost_pulse && !bsy_oe && data_oe == 8'b0));

  // R4
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_pulse |-> (lost_flag && !bsy_oe && !sel_oe && !go_sel));

  // R3
  one_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(data_oe));

  // R6
  settle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(go_sel) && mode == M_FULL) |-> $past(sel_oe));

  // R9
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && (st == S_FREE || st == S_ARB || st == S_SETTLE)) |=> $stable(ctl_rdata));

endmodule

// File: tb/tb_scsi_arbiter.sv
module tb_scsi_arbiter;
  localparam int F = 3, A = 4, S = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00, ctl_rdata;
  logic [2:0] my_id = 3'd0;
  logic tb_bsy = 1'b0, tb_sel = 1'b0;
  logic [7:0] tb_data = 8'h00;
  logic bsy_oe, sel_oe, won_pulse, lost_pulse, lost_flag, go_sel;
  logic [7:0] data_oe;
  int checks = 0, fails = 0, n;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scsi_arbiter #(.FREE_CYCLES(F), .ARB_DELAY(A), .SETTLE_CYCLES(S)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .my_id(my_id),
    .bsy_n_in(~(tb_bsy | bsy_oe)), .sel_n_in(~(tb_sel | sel_oe)),
    .data_n_in(~(tb_data | data_oe)),
    .bsy_oe(bsy_oe), .sel_oe(sel_oe), .data_oe(data_oe),
    .won_pulse(won_pulse), .lost_pulse(lost_pulse), .lost_flag(lost_flag),
    .go_sel(go_sel));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wait_pulse();
    n = 0;
    while (!won_pulse && !lost_pulse && n < 200) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(ctl_rdata == 8'hC0, "R1 reg", ctl_rdata, 8'hC0);
    chk(!bsy_oe && !sel_oe && data_oe == 0 && !won_pulse && !lost_pulse && !lost_flag && !go_sel,
        "R1 outputs", {bsy_oe, sel_oe, go_sel, lost_flag}, 0);

    // R10 field layout
    wr(8'h1F);
    chk(ctl_rdata == 8'h1B, "R10 fields", ctl_rdata, 8'h1B);
    chk(!bsy_oe, "R10 no start", bsy_oe, 0);

    // R5 R6 R3 full-mode sweep
    for (int id = 0; id < 8; id++) begin
      for (int c = -1; c < 8; c++) begin
        bit win;
        my_id = 3'(id);
        tb_data = (c < 0) ? 8'h00 : 8'(1 << c);
        win = (c <= id);
        wr(8'hE0);
        chk(ctl_rdata[5] == 1'b1, "R10 start reads 1", ctl_rdata[5], 1);
        wait_pulse();
        chk(n == F + A, "R5 decision cycle", n, F + A);
        chk(won_pulse == win && lost_pulse == !win, "R5 outcome", won_pulse, win);
        if (win) begin
          chk(bsy_oe && sel_oe && data_oe == 8'(1 << id), "R6 drive", data_oe, 1 << id);
          repeat (S - 1) @(negedge clk);
          chk(!go_sel, "R6 ready early", go_sel, 0);
          @(negedge clk);
          chk(go_sel && sel_oe, "R6 ready", go_sel, 1);
          wr(8'hC0);
          chk(!bsy_oe && !sel_oe && data_oe == 0 && !go_sel, "R11 release", bsy_oe, 0);
        end else begin
          chk(!bsy_oe && data_oe == 0 && lost_flag && ctl_rdata[5] == 0, "R5 loss release", data_oe, 0);
        end
      end
    end
    tb_data = 8'h00;

    // R7 simple mode
    for (int id = 0; id < 8; id++) begin
      my_id = 3'(id);
      wr(8'h20);
      chk(lost_flag == 0, "R11 flag cleared", lost_flag, 0);
      wait_pulse();
      chk(n == F + A && won_pulse && go_sel && !sel_oe, "R7 simple win", {won_pulse, go_sel, sel_oe}, 6);
      chk(data_oe == 8'(1 << id) && bsy_oe, "R3 id drive", data_oe, 1 << id);
      wr(8'h00);
      chk(!bsy_oe && !go_sel, "R11 release", bsy_oe, 0);
    end

    // R2 busy bus delays arbitration
    my_id = 3'd2;
    tb_bsy = 1'b1;
    wr(8'hE0);
    n = 0;
    for (int k = 1; k < 10; k++) begin
      @(negedge clk);
      chk(!bsy_oe && data_oe == 0, "R2 wait busy", bsy_oe, 0);
    end
    tb_bsy = 1'b0;
    n = 0;
    while (!bsy_oe && n < 50) begin @(negedge clk); n++; end
    chk(n == F, "R2 claim after free", n, F);
    chk(data_oe == 8'h04 && !sel_oe, "R3 arb drive", data_oe, 4);
    n = 0;
    while (!won_pulse && n < 50) begin @(negedge clk); n++; end
    chk(n == A, "R5 delay after claim", n, A);
    repeat (S) @(negedge clk);
    wr(8'hC0);

    // R4 foreign select
    my_id = 3'd7;
    wr(8'hE0);
    repeat (F + 1) @(negedge clk);
    tb_sel = 1'b1;
    @(negedge clk);
    chk(lost_pulse && !bsy_oe && data_oe == 0, "R4 foreign select", lost_pulse, 1);
    chk(lost_flag && ctl_rdata[5] == 0, "R4 flag", lost_flag, 1);
    tb_sel = 1'b0;
    @(negedge clk);
    chk(!lost_pulse && lost_flag, "R4 one-cycle pulse", lost_pulse, 0);

    // R9 write while busy ignored
    wr(8'hE0);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 8'h00;
    @(negedge clk); ctl_we = 1'b0;
    chk(ctl_rdata == 8'hE0, "R9 reg unchanged", ctl_rdata, 8'hE0);
    n = 2;
    while (!won_pulse && !lost_pulse && n < 200) begin @(negedge clk); n++; end
    chk(n == F + A && won_pulse && sel_oe, "R9 timing kept", n, F + A);
    repeat (S) @(negedge clk);
    wr(8'hC0);

    // R8 reserved modes
    wr(8'h60);
    chk(ctl_rdata == 8'h40, "R8 reg 01", ctl_rdata, 8'h40);
    for (int k = 0; k < F + A + 2; k++) begin
      @(negedge clk);
      chk(!bsy_oe && data_oe == 0 && !won_pulse && !lost_pulse, "R8 idle 01", bsy_oe, 0);
    end
    wr(8'hA0);
    chk(ctl_rdata == 8'h80, "R8 reg 10", ctl_rdata, 8'h80);
    repeat (F + A + 2) @(negedge clk);
    chk(!bsy_oe && !won_pulse && !lost_pulse && !go_sel, "R8 idle 10", bsy_oe, 0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule